// File: doc/BRIEF.md
# Frame Keyed Stream Scrambler

This block whitens and encrypts a serial bit stream one bit at a time, frame by frame. An 11-stage linear feedback shift register produces a keystream, and each accepted payload bit leaves the block XORed with the register's top stage, one clock later. When a frame starts, the register's low eight stages take an 8-bit user key and its top three stages are set to one. A scramble enable, sampled only at frame start, selects whether that frame is scrambled or passes through unchanged.

XOR with a keystream undoes itself, so the same block serves as the descrambler on the receive side. A receiver loaded with the key the transmitter used gets the plain data back. A receiver holding any other key gets noise. The block drives its output register and nothing else: it does no spreading, correlation or framing.

Top module: `fks_scrambler`

## Requirements
- R1: While reset is held and right after it is released, bit_valid_o and bit_o are both 0. Until the first start-of-frame pulse the block is in pass-through.
- R2: Each bit_valid_i cycle produces exactly one bit_valid_o cycle, exactly one clock later. No other cycle raises bit_valid_o.
- R3: In a scrambled frame, bit_o equals the input bit XOR register stage 10 (the most significant stage). After each such bit the register moves to {s[9:0], s[10]^s[4]^s[2]^s[1]}, where s[k] is stage k.
- R4: A start-of-frame pulse loads the register with {3'b111, key_i}: the key goes into stages 7..0 and ones go into stages 10..8. In a scrambled frame the first bit is therefore always inverted.
- R5: The register moves only on cycles that carry a data bit. Idle gaps inside a frame leave the keystream where it was.
- R6: scr_en_i is sampled only on a start-of-frame cycle. Changing it in mid-frame does not affect the frame in progress.
- R7: In a frame started with scr_en_i low, every bit comes out unchanged with the same one-cycle latency. The register does not move during such a frame.
- R8: A data bit presented in the same cycle as the start-of-frame pulse is the first bit of the new frame. It uses the new seed and the new enable.
- R9: Feeding a scrambled frame back through the block with the same key restores the original bits. An all-zero key still yields a keystream that is not all zero.
- R10: Changing key_i in mid-frame has no effect until the next start-of-frame pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sof_i | input | 1 | Start-of-frame pulse: reloads the seed and samples the enable |
| scr_en_i | input | 1 | Scramble enable for the frame being started |
| key_i | input | 8 | User key for stages 7..0 |
| bit_i | input | 1 | Serial data bit |
| bit_valid_i | input | 1 | bit_i carries a data bit this cycle |
| bit_o | output | 1 | Scrambled or passed-through bit |
| bit_valid_o | output | 1 | bit_o carries a data bit this cycle |

## Verification
Scrambled frames of all-zero data expose the raw keystream, which separates a wrong tap set or a wrong seed from a correct one. Alternating and random data confirm that the data enters only through the XOR. Bursts broken by idle gaps tell a register that moves per accepted bit from one that moves per clock. Frames with the enable or key toggled in mid-frame, a pulse that coincides with a data bit, an all-zero key, and a round trip of the scrambled output through a second keyed frame separate the per-frame latching and the self-inverse property from near misses.

// File: rtl/fks_pkg.sv
package fks_pkg;
  // Register length follows the polynomial degree
  localparam int LFSR_W = 11;
  localparam int KEY_W  = 8;
  localparam int FILL_W = LFSR_W - KEY_W;
  // Stages feeding the new stage 0: 10, 4, 2, 1
  localparam logic [LFSR_W-1:0] TAP_MASK = 11'b100_0001_0110;

  typedef logic [LFSR_W-1:0] lfsr_t;
  typedef logic [KEY_W-1:0]  key_t;

  // One keystream step: shift up, feedback into stage 0
  function automatic lfsr_t lfsr_step(input lfsr_t s);
    return {s[LFSR_W-2:0], ^(s & TAP_MASK)};
  endfunction

  // Frame seed: ones above the key so the register never starts at zero
  function automatic lfsr_t seed_of(input key_t k);
    return {{FILL_W{1'b1}}, k};
  endfunction

  // Output bit: data XOR top stage when scrambling
  function automatic logic mix_bit(input logic d, input logic en, input lfsr_t s);
    return d ^ (en & s[LFSR_W-1]);
  endfunction
endpackage

// File: rtl/fks_frame_ctl.sv
module fks_frame_ctl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sof_i,
  input  logic scr_en_i,
  output logic frame_en_q,
  output logic eff_en
);
  // Enable seen by this cycle's bit: a new frame uses the enable it brings
  assign eff_en = sof_i ? scr_en_i : frame_en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    frame_en_q <= 1'b0;
    else if (sof_i) frame_en_q <= scr_en_i;
  end
endmodule

// File: rtl/fks_keystream.sv
module fks_keystream
  import fks_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  load_i,
  input  key_t  key_i,
  input  logic  step_i,
  output lfsr_t state_q,
  output lfsr_t eff_state,
  output logic  ks_bit
);
  // State seen by this cycle's bit: the fresh seed on a frame start
  assign eff_state = load_i ? seed_of(key_i) : state_q;
  assign ks_bit    = eff_state[LFSR_W-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     state_q <= seed_of('0);
    else if (step_i) state_q <= lfsr_step(eff_state);
    else if (load_i) state_q <= eff_state;
  end
endmodule

// File: rtl/fks_mixer.sv
module fks_mixer
  import fks_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  bit_i,
  input  logic  bit_valid_i,
  input  logic  eff_en,
  input  lfsr_t eff_state,
  output logic  bit_o,
  output logic  bit_valid_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_o       <= 1'b0;
      bit_valid_o <= 1'b0;
    end else begin
      bit_valid_o <= bit_valid_i;
      if (bit_valid_i) bit_o <= mix_bit(bit_i, eff_en, eff_state);
    end
  end
endmodule

// File: rtl/fks_scrambler.sv
module fks_scrambler
  import fks_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sof_i,
  input  logic             scr_en_i,
  input  logic [KEY_W-1:0] key_i,
  input  logic             bit_i,
  input  logic             bit_valid_i,
  output logic             bit_o,
  output logic             bit_valid_o
);
  // Named internal events, observed by the bound checker
  logic  frame_en_w;
  logic  eff_en_w;
  logic  step_w;
  logic  ks_bit_w;
  lfsr_t state_w;
  lfsr_t eff_state_w;

  assign step_w = bit_valid_i & eff_en_w;

  fks_frame_ctl u_ctl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sof_i      (sof_i),
    .scr_en_i   (scr_en_i),
    .frame_en_q (frame_en_w),
    .eff_en     (eff_en_w)
  );

  fks_keystream u_ks (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (sof_i),
    .key_i     (key_i),
    .step_i    (step_w),
    .state_q   (state_w),
    .eff_state (eff_state_w),
    .ks_bit    (ks_bit_w)
  );

  fks_mixer u_mix (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bit_i       (bit_i),
    .bit_valid_i (bit_valid_i),
    .eff_en      (eff_en_w),
    .eff_state   (eff_state_w),
    .bit_o       (bit_o),
    .bit_valid_o (bit_valid_o)
  );
endmodule

// File: rtl/fks_scrambler_chk.sv
module fks_scrambler_chk
  import fks_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             sof_i,
  input logic             scr_en_i,
  input logic [KEY_W-1:0] key_i,
  input logic             bit_i,
  input logic             bit_valid_i,
  input logic             bit_o,
  input logic             bit_valid_o,
  input logic             frame_en_q,
  input lfsr_t            state_q
);
  AST_VALID_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_valid_i |=> bit_valid_o); // R2
  AST_NO_SPURIOUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bit_valid_i |=> !bit_valid_o); // R2
  AST_STEP_POLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_valid_i && !sof_i && frame_en_q) |=> state_q == lfsr_step($past(state_q))); // R3
  AST_OUT_XOR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_valid_i && !sof_i && frame_en_q) |=> bit_o == ($past(bit_i) ^ $past(state_q[LFSR_W-1]))); // R3
  AST_SEED_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sof_i && !(bit_valid_i && scr_en_i)) |=> state_q == seed_of($past(key_i))); // R4
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bit_valid_i && !sof_i) |=> $stable(state_q)); // R5
  AST_EN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sof_i |=> $stable(frame_en_q)); // R6
  AST_BYPASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_valid_i && ((sof_i && !scr_en_i) || (!sof_i && !frame_en_q))) |=> bit_o == $past(bit_i)); // R7
  AST_NO_LOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q != '0); // R9
endmodule

bind fks_scrambler fks_scrambler_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .sof_i       (sof_i),
  .scr_en_i    (scr_en_i),
  .key_i       (key_i),
  .bit_i       (bit_i),
  .bit_valid_i (bit_valid_i),
  .bit_o       (bit_o),
  .bit_valid_o (bit_valid_o),
  .frame_en_q  (frame_en_w),
  .state_q     (state_w)
);

// File: tb/fks_scrambler_bench.sv
module fks_scrambler_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       sof_i = 1'b0;
  logic       scr_en_i = 1'b0;
  logic [7:0] key_i = 8'h00;
  logic       bit_i = 1'b0;
  logic       bit_valid_i = 1'b0;
  logic       bit_o;
  logic       bit_valid_o;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit done = 1'b0;

  // Bench-side keystream model, written from the requirements
  logic [10:0] m_s = {3'b111, 8'h00};
  logic        m_en = 1'b0;
  bit          exp_q[$];
  string       tag_q[$];
  bit          plain_keep[$];
  bit          scr_keep[$];
  int          ones_seen;

  always #10 clk_i = ~clk_i;  // 50 MHz

  fks_scrambler u_fks_scrambler (
    .clk_i(clk_i), .rst_ni(rst_ni), .sof_i(sof_i), .scr_en_i(scr_en_i),
    .key_i(key_i), .bit_i(bit_i), .bit_valid_i(bit_valid_i),
    .bit_o(bit_o), .bit_valid_o(bit_valid_o)
  );

  function automatic logic [10:0] m_next(input logic [10:0] s);
    logic fb;
    fb = s[10] ^ s[4] ^ s[2] ^ s[1];
    return {s[9:0], fb};
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Driver: one cycle of stimulus, expected result pushed to the scoreboard
  task automatic drive(input bit sof, input bit en, input logic [7:0] key,
                       input bit vld, input bit b, input string tag);
    bit e;
    sof_i = sof; scr_en_i = en; key_i = key; bit_valid_i = vld; bit_i = b;
    if (sof) begin
      m_en = en;
      m_s  = {3'b111, key};
    end
    if (vld) begin
      e = b ^ (m_en & m_s[10]);
      exp_q.push_back(e);
      tag_q.push_back(tag);
      scr_keep.push_back(e);
      if (m_en) m_s = m_next(m_s);
    end
    @(posedge clk_i); #1;
    sof_i = 1'b0; bit_valid_i = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk_i); #1;
    end
  endtask

  task automatic drain();
    idle(3);
    check(exp_q.size() == 0, "R2", exp_q.size(), 0);
  endtask

  // Monitor: pops and compares away from the active edge
  always @(negedge clk_i) begin
    if (rst_ni && bit_valid_o) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R2", 1, 0);
      end else begin
        bit e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (bit_o) ones_seen++;
        check(bit_o == e, t, bit_o, e);
      end
    end
  end

  // Watchdog
  always @(posedge clk_i) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      check(1'b0, "watchdog", cycles, 100000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    idle(2);
    check(bit_valid_o == 1'b0 && bit_o == 1'b0, "R1", {bit_valid_o, bit_o}, 0);
    @(negedge clk_i); rst_ni = 1'b1;
    @(posedge clk_i); #1;
    check(bit_valid_o == 1'b0 && bit_o == 1'b0, "R1", {bit_valid_o, bit_o}, 0);

    // R1: pass-through before the first frame start
    for (int i = 0; i < 6; i++) drive(0, 0, 8'h00, 1, i[0], "R1");
    drain();

    // R3/R4: zero data exposes keystream; first bit is inverted
    drive(1, 1, 8'hA5, 0, 0, "R4");
    drive(0, 1, 8'hA5, 1, 0, "R4");
    for (int i = 0; i < 40; i++) drive(0, 1, 8'hA5, 1, 0, "R3");
    drain();

    // R3: alternating and random data
    drive(1, 1, 8'h3C, 0, 0, "R4");
    for (int i = 0; i < 32; i++) drive(0, 1, 8'h3C, 1, i[0], "R3");
    for (int i = 0; i < 32; i++) drive(0, 1, 8'h3C, 1, 1'($urandom), "R3");
    drain();

    // R5: gaps inside a frame
    drive(1, 1, 8'h5A, 0, 0, "R4");
    for (int i = 0; i < 20; i++) begin
      drive(0, 1, 8'h5A, 1, 1'($urandom), "R5");
      idle(i % 3);
    end
    drain();

    // R6 and R10: enable and key toggled mid-frame
    drive(1, 1, 8'h81, 0, 0, "R4");
    for (int i = 0; i < 24; i++) drive(0, i[1], 8'(i * 7), 1, 1'($urandom), "R6");
    drive(1, 0, 8'h81, 0, 0, "R7");
    for (int i = 0; i < 24; i++) drive(0, 1, 8'(i * 13), 1, 1'($urandom), "R6");
    drive(1, 1, 8'h42, 0, 0, "R4");
    for (int i = 0; i < 24; i++) drive(0, 1, 8'(~i), 1, 1'b1, "R10");
    drain();

    // R7: disabled frame, register frozen: a later bit with no new start still plain
    drive(1, 0, 8'hFF, 0, 0, "R7");
    for (int i = 0; i < 30; i++) drive(0, 0, 8'hFF, 1, 1'($urandom), "R7");
    drain();

    // R8: start pulse carries the first bit, back-to-back frames
    drive(1, 1, 8'h17, 1, 0, "R8");
    for (int i = 0; i < 10; i++) drive(0, 1, 8'h17, 1, 1'b0, "R8");
    drive(1, 0, 8'h17, 1, 1, "R8");
    drive(1, 1, 8'hE2, 1, 1, "R8");
    for (int i = 0; i < 10; i++) drive(0, 1, 8'hE2, 1, 1'b1, "R8");
    drain();

    // R9: all-zero key still produces a nonzero keystream
    ones_seen = 0;
    drive(1, 1, 8'h00, 0, 0, "R9");
    for (int i = 0; i < 40; i++) drive(0, 1, 8'h00, 1, 1'b0, "R9");
    drain();
    check(ones_seen > 0, "R9", ones_seen, 1);

    // R9: round trip with the same key restores the data
    plain_keep.delete(); scr_keep.delete();
    drive(1, 1, 8'h6B, 0, 0, "R9");
    for (int i = 0; i < 48; i++) begin
      bit b;
      b = 1'($urandom);
      plain_keep.push_back(b);
      drive(0, 1, 8'h6B, 1, b, "R9");
    end
    drain();
    begin
      bit cip[$];
      cip = scr_keep;
      drive(1, 1, 8'h6B, 0, 0, "R9");
      for (int i = 0; i < cip.size(); i++) begin
        drive(0, 1, 8'h6B, 1, cip[i], "R9");
      end
      drain();
      check(scr_keep.size() == 2 * plain_keep.size(), "R9", scr_keep.size(), 2 * plain_keep.size());
      for (int i = 0; i < plain_keep.size(); i++)
        check(scr_keep[plain_keep.size() + i] == plain_keep[i], "R9",
              scr_keep[plain_keep.size() + i], plain_keep[i]);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule